// File: doc/BRIEF.md
# Cascaded serial word loader

This block is the host side of a three-wire serial link (clock, data, load) feeding one or more daisy-chained octal channel-register devices. The client hands over one 12-bit word per device through a valid/ready handshake: a 4-bit channel address and an 8-bit value. Once one word per device in the chain has been collected, the block shifts all of them out back to back on a divided serial clock. It then raises a single load strobe that every device in the chain shares.

The timing is set in system-clock cycles: the length of each serial clock phase, the settle time from the last rising edge to load, the load width and the recovery gap after load. The defaults meet the minimum pulse widths and gaps of the receiving devices with a 100 MHz system clock. Each serial bit changes together with the falling edge of the serial clock, so it is held for a full half period on each side of the rising edge. The first word accepted is meant for the device farthest down the chain and is shifted first. A device that should keep its registers gets a no-op word.

Top module: `octal_frame_loader`

## Requirements
- R1: Each word is sent as 12 bits, with the 4-bit address first and the 8-bit value after it, each field most significant bit first. Words go out in the order they were accepted, and the serial data is sampled on the rising edge of the serial clock.
- R2: One transfer produces exactly 12*CASCADE_N rising edges of the serial clock and then exactly one load pulse.
- R3: Inside a transfer, the serial clock stays high for exactly HALF_CYC cycles on every high phase, and every low phase between two rising edges also lasts exactly HALF_CYC cycles (60 ns each with the defaults, minimum 50 ns).
- R4: The serial data does not change while the serial clock is high.
- R5: The load strobe rises exactly HALF_CYC+SETTLE_CYC cycles after the last rising serial clock edge, which is at least 30 ns. The serial clock stays low for as long as load is high.
- R6: The load pulse is exactly LOAD_CYC cycles wide (60 ns with the defaults, minimum 50 ns).
- R7: No rising serial clock edge comes earlier than GAP_CYC+HALF_CYC+1 cycles after load falls (at least 60 ns).
- R8: in_ready is high only while the block is idle. It is low from the cycle after the last word of a group is accepted until the recovery gap has ended, and a word offered while in_ready is low is not taken.
- R9: xfer_done is high for exactly one cycle, GAP_CYC cycles after load falls, and in_ready is high in that same cycle.
- R10: After reset the serial clock, serial data, load and xfer_done are low and in_ready is high.
- R11: In the chain, device k counted from the host (k = 0 nearest) receives the word accepted in position CASCADE_N-1-k of the group. Address codes 0001 to 1000 select channels 1 to 8. Codes 0000 and 1001 to 1111 are passed through unchanged and leave that device's registers as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The block is idle and takes the offered word |
| in_addr | input | 4 | Channel address code of the offered word |
| in_data | input | 8 | Channel value of the offered word |
| ser_clk | output | 1 | Serial clock to the chain |
| ser_data | output | 1 | Serial data to the first device in the chain |
| ser_load | output | 1 | Shared load strobe |
| xfer_done | output | 1 | One-cycle pulse when a transfer has ended |

## Verification
The assertions assume that in_valid and the word fields are changed only between clock edges. They also assume that every group contains exactly CASCADE_N words, with no word abandoned part way through. The bench drives all inputs on the falling system-clock edge and always completes a group. It adds random idle gaps between words, uses random address codes that include the no-op codes, and uses directed words at the extremes of the value range. It also holds a junk word on the input while a transfer is running, to show that the word is refused.

// File: rtl/olf_pkg.sv
// Package: shared widths and sequencer state for the cascaded serial word loader.
// Assumes a 4-bit address field followed by an 8-bit value field per word.
package olf_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int WORD_W = ADDR_W + DATA_W;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOW    = 3'd1,
        ST_HIGH   = 3'd2,
        ST_SETTLE = 3'd3,
        ST_LOAD   = 3'd4,
        ST_GAP    = 3'd5
    } olf_state_e;
endpackage

// File: rtl/olf_word_buffer.sv
// Word buffer: collects CASCADE_N words into one wide shift register and
// presents its most significant bit as the serial data bit.
// Assumes push and shift never occur in the same cycle (sequencer guarantees).
module olf_word_buffer #(
    parameter int CASCADE_N = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [olf_pkg::WORD_W-1:0] push_word,
    input  logic                      shift,
    output logic                      last_word,
    output logic                      msb
);
    import olf_pkg::*;

    localparam int BUF_W  = WORD_W * CASCADE_N;
    localparam int WCNT_W = (CASCADE_N > 1) ? $clog2(CASCADE_N) : 1;

    logic [BUF_W-1:0]  buf_q;
    logic [WCNT_W-1:0] wcnt_q;

    assign last_word = (wcnt_q == WCNT_W'(CASCADE_N - 1));
    assign msb       = buf_q[BUF_W-1];

    // Append accepted words at the low end; move bits out at the high end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else if (push) begin
            buf_q <= (buf_q << WORD_W) | BUF_W'(push_word);
        end else if (shift) begin
            buf_q <= buf_q << 1;
        end
    end

    // Count the words of the current group and wrap after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
        end else if (push) begin
            wcnt_q <= last_word ? '0 : wcnt_q + 1'b1;
        end
    end

    a_r1_push_not_during_shift : assert property (@(posedge clk) disable iff (!rst_n)
        !(push && shift));
    a_r8_group_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
        wcnt_q <= WCNT_W'(CASCADE_N - 1));
endmodule

// File: rtl/olf_phase_timer.sv
// Phase timer: one down-counter shared by all timed phases. Loaded with
// duration-1 on entry to a phase; expired is high in the phase's last cycle.
// Assumes the sequencer reloads it only when it has run out.
module olf_phase_timer #(
    parameter int COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [COUNT_W-1:0] load_val,
    output logic               expired
);
    logic [COUNT_W-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    // Reload on request, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_en) begin
            cnt_q <= load_val;
        end else if (!expired) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    a_r3_reload_at_expiry : assert property (@(posedge clk) disable iff (!rst_n)
        load_en |-> expired);
endmodule

// File: rtl/olf_sequencer.sv
// Sequencer: handshake, serial clock phases, bit counting, load strobe and
// recovery gap. All outputs decode from the registered state.
// Assumes every duration parameter is at least 1 and fits in COUNT_W bits.
module olf_sequencer #(
    parameter int CASCADE_N  = 2,
    parameter int HALF_CYC   = 6,
    parameter int SETTLE_CYC = 4,
    parameter int LOAD_CYC   = 6,
    parameter int GAP_CYC    = 7,
    parameter int COUNT_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               last_word,
    input  logic               tmr_expired,
    output logic               push,
    output logic               shift,
    output logic               tmr_load,
    output logic [COUNT_W-1:0] tmr_val,
    output logic               sclk,
    output logic               load,
    output logic               ready,
    output logic               done
);
    import olf_pkg::*;

    localparam int TOTAL_BITS = WORD_W * CASCADE_N;
    localparam int BIT_W      = $clog2(TOTAL_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(TOTAL_BITS - 1);

    olf_state_e       state_q, state_d;
    logic [BIT_W-1:0] bit_q;
    logic             done_q;

    assign ready = (state_q == ST_IDLE);
    assign push  = ready && in_valid;
    assign sclk  = (state_q == ST_HIGH);
    assign load  = (state_q == ST_LOAD);
    assign done  = done_q;

    // Next state, phase timer reload and shift request.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        shift    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (push && last_word) begin
                    state_d  = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = COUNT_W'(HALF_CYC - 1);
                end
            end
            ST_LOW: begin
                if (tmr_expired) begin
                    state_d  = ST_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = COUNT_W'(HALF_CYC - 1);
                end
            end
            ST_HIGH: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (bit_q == LAST_BIT) begin
                        state_d = ST_SETTLE;
                        tmr_val = COUNT_W'(SETTLE_CYC - 1);
                    end else begin
                        state_d = ST_LOW;
                        shift   = 1'b1;
                        tmr_val = COUNT_W'(HALF_CYC - 1);
                    end
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    state_d  = ST_LOAD;
                    tmr_load = 1'b1;
                    tmr_val  = COUNT_W'(LOAD_CYC - 1);
                end
            end
            ST_LOAD: begin
                if (tmr_expired) begin
                    state_d  = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = COUNT_W'(GAP_CYC - 1);
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bit counter: cleared while idle, advanced on each falling serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                 bit_q <= '0;
        else if (state_q == ST_IDLE) bit_q <= '0;
        else if (shift)             bit_q <= bit_q + 1'b1;
    end

    // Completion pulse when the recovery gap runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == ST_GAP) && tmr_expired;
    end

    a_r2_bit_index_bound : assert property (@(posedge clk) disable iff (!rst_n)
        bit_q <= LAST_BIT);
    a_r3_edge_on_expiry : assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk) || $fell(sclk)) |-> $past(tmr_expired));
    a_r6_load_end_on_expiry : assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load) |-> $past(tmr_expired));
    a_r8_busy_after_last : assert property (@(posedge clk) disable iff (!rst_n)
        (push && last_word) |=> !ready);
    a_r9_done_single : assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/octal_frame_loader.sv
// Cascaded serial word loader top: joins word buffer, phase timer and
// sequencer. Assumes clients present exactly CASCADE_N words per group,
// farthest device first.
module octal_frame_loader #(
    parameter int CASCADE_N  = 2,
    parameter int HALF_CYC   = 6,
    parameter int SETTLE_CYC = 4,
    parameter int LOAD_CYC   = 6,
    parameter int GAP_CYC    = 7,
    parameter int COUNT_W    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [3:0] in_addr,
    input  logic [7:0] in_data,
    output logic       ser_clk,
    output logic       ser_data,
    output logic       ser_load,
    output logic       xfer_done
);
    import olf_pkg::*;

    logic               push, shift, last_word, tmr_load, tmr_expired;
    logic [COUNT_W-1:0] tmr_val;
    logic [COUNT_W-1:0] gap_q;

    olf_word_buffer #(.CASCADE_N(CASCADE_N)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_word ({in_addr, in_data}),
        .shift     (shift),
        .last_word (last_word),
        .msb       (ser_data)
    );

    olf_phase_timer #(.COUNT_W(COUNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    olf_sequencer #(
        .CASCADE_N (CASCADE_N),
        .HALF_CYC  (HALF_CYC),
        .SETTLE_CYC(SETTLE_CYC),
        .LOAD_CYC  (LOAD_CYC),
        .GAP_CYC   (GAP_CYC),
        .COUNT_W   (COUNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .last_word  (last_word),
        .tmr_expired(tmr_expired),
        .push       (push),
        .shift      (shift),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .sclk       (ser_clk),
        .load       (ser_load),
        .ready      (in_ready),
        .done       (xfer_done)
    );

    // Checker counter: cycles since load was last high, saturating at GAP_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n)                         gap_q <= COUNT_W'(GAP_CYC);
        else if (ser_load)                  gap_q <= '0;
        else if (gap_q < COUNT_W'(GAP_CYC)) gap_q <= gap_q + 1'b1;
    end

    a_r4_data_steady_high : assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
    a_r5_no_clock_with_load : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_load) |-> !ser_clk);
    a_r7_gap_before_clock : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> (gap_q >= COUNT_W'(GAP_CYC)));
endmodule

// File: tb/octal_frame_loader_test.sv
module octal_frame_loader_test;
    localparam int N      = 2;
    localparam int HALF   = 6;
    localparam int SETTLE = 4;
    localparam int LDW    = 6;
    localparam int GAP    = 7;
    localparam int BITS   = 12 * N;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] in_addr = '0;
    logic [7:0] in_data = '0;
    logic       in_ready, ser_clk, ser_data, ser_load, xfer_done;

    octal_frame_loader #(.CASCADE_N(N), .HALF_CYC(HALF), .SETTLE_CYC(SETTLE),
                         .LOAD_CYC(LDW), .GAP_CYC(GAP), .COUNT_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_data(in_data), .ser_clk(ser_clk),
        .ser_data(ser_data), .ser_load(ser_load), .xfer_done(xfer_done));

    always #5 clk = ~clk;

    int tests = 0, fails = 0;
    int frames_done = 0;
    bit monitoring = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected stream and device register mirror, built by the driver.
    logic [BITS-1:0] exp_chain = '0;
    logic [7:0] dev     [N][8];
    logic [7:0] exp_dev [N][8];

    // Monitor state.
    logic [BITS-1:0] chain = '0;
    bit p_clk = 0, p_load = 0, p_data = 0, p_done = 0, seen_load = 0;
    int rises = 0, hi_run = 0, lo_run = 0, since_rise = 0, since_lf = 0, load_run = 0;
    int m_delay = -1, m_width = -1;
    int v_hi = 0, v_lo = 0, v_sd = 0, v_cl = 0, v_gap = 0, v_rdy = 0, v_done = 0;

    always @(negedge clk) begin
        if (monitoring) begin
            if (ser_clk && !p_clk) begin
                if (rises > 0 && lo_run != HALF) v_lo++;
                if (seen_load && since_lf < GAP + HALF + 1) v_gap++;
                chain = {chain[BITS-2:0], ser_data};
                rises++; since_rise = 0; hi_run = 1;
            end else if (ser_clk) begin
                hi_run++; since_rise++;
                if (ser_data != p_data) v_sd++;
            end else if (p_clk) begin
                if (hi_run != HALF) v_hi++;
                lo_run = 1; since_rise++;
            end else begin
                lo_run++; since_rise++;
            end
            if (ser_load && !p_load) begin
                m_delay = since_rise; load_run = 1;
                if (ser_clk) v_cl++;
                for (int d = 0; d < N; d++) begin
                    logic [11:0] w;
                    w = chain[12*d +: 12];
                    if (w[11:8] >= 4'd1 && w[11:8] <= 4'd8) dev[d][w[11:8]-1] = w[7:0];
                end
            end else if (ser_load) begin
                load_run++;
                if (ser_clk) v_cl++;
            end else if (p_load) begin
                m_width = load_run; since_lf = 0; seen_load = 1;
            end else begin
                since_lf++;
            end
            if ((ser_clk || ser_load) && in_ready) v_rdy++;
            if (xfer_done && p_done) v_done++;
            if (xfer_done) begin
                int mism;
                mism = 0;
                for (int d = 0; d < N; d++)
                    for (int c = 0; c < 8; c++)
                        if (dev[d][c] != exp_dev[d][c]) mism++;
                chk(rises == BITS, "R2 rising edges per transfer", rises, BITS);
                chk(chain == exp_chain, "R1 serial word stream", chain, exp_chain);
                chk(v_hi == 0 && v_lo == 0, "R3 clock phase widths", v_hi + v_lo, 0);
                chk(v_sd == 0, "R4 data change while clock high", v_sd, 0);
                chk(m_delay == HALF + SETTLE && v_cl == 0, "R5 load start and quiet clock",
                    m_delay, HALF + SETTLE);
                chk(m_width == LDW, "R6 load width", m_width, LDW);
                chk(v_gap == 0, "R7 gap after load", v_gap, 0);
                chk(v_rdy == 0, "R8 ready low while busy", v_rdy, 0);
                chk(in_ready && v_done == 0 && since_lf == GAP, "R9 done pulse",
                    since_lf, GAP);
                chk(mism == 0, "R11 cascade placement and no-op codes", mism, 0);
                rises = 0; chain = '0; v_hi = 0; v_lo = 0; v_sd = 0; v_cl = 0;
                v_gap = 0; v_rdy = 0; v_done = 0; m_delay = -1; m_width = -1;
                frames_done++;
            end
            p_clk = ser_clk; p_load = ser_load; p_data = ser_data; p_done = xfer_done;
        end
    end

    // Offer one group of N words, farthest device first.
    task automatic send_group(input logic [11:0] w0, input logic [11:0] w1, input bit junk);
        logic [11:0] ws [N];
        int target;
        ws[0] = w0; ws[1] = w1;
        target = frames_done + 1;
        for (int j = 0; j < N; j++) begin
            int idle;
            idle = $urandom % 4;
            in_valid = 1'b0;
            for (int k = 0; k < idle; k++) @(negedge clk);
            in_valid = 1'b1; in_addr = ws[j][11:8]; in_data = ws[j][7:0];
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            exp_chain = {exp_chain[BITS-13:0], ws[j]};
            if (ws[j][11:8] >= 4'd1 && ws[j][11:8] <= 4'd8)
                exp_dev[N-1-j][ws[j][11:8]-1] = ws[j][7:0];
        end
        in_valid = 1'b0;
        chk(!in_ready, "R8 ready drops after last word", in_ready, 0);
        if (junk) begin
            in_valid = 1'b1; in_addr = 4'h3; in_data = 8'h5A;
            for (int k = 0; k < 30; k++) @(negedge clk);
            in_valid = 1'b0;
        end
        while (frames_done < target) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int d = 0; d < N; d++)
            for (int c = 0; c < 8; c++) begin
                dev[d][c] = 8'h80; exp_dev[d][c] = 8'h80;
            end
        repeat (3) @(negedge clk);
        chk(!ser_clk && !ser_data && !ser_load && !xfer_done && in_ready, "R10 reset state",
            {ser_clk, ser_data, ser_load, xfer_done, in_ready}, 5'b00001);
        rst_n = 1'b1;
        monitoring = 1'b1;
        @(negedge clk);
        chk(!ser_clk && !ser_load && in_ready, "R10 idle after reset",
            {ser_clk, ser_load, in_ready}, 3'b001);
        send_group(12'h0AA, 12'h0AA, 1'b0);           // both no-op
        send_group(12'h8FF, 12'h100, 1'b0);           // channel 8 full, channel 1 zero
        send_group(12'hF12, 12'h47E, 1'b0);           // invalid code then channel 4
        send_group(12'h2C3, 12'h9B1, 1'b1);           // junk offered while busy
        send_group(12'h155, 12'h8AA, 1'b0);
        for (int f = 0; f < 20; f++)
            send_group({4'($urandom % 16), 8'($urandom)}, {4'($urandom % 16), 8'($urandom)}, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1500000;
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule